// File: doc/BRIEF.md
# Cross-Domain Trigger Pulse Endpoint

This block turns trigger writes issued on a host clock into single-cycle pulses in a user clock that is fully asynchronous to it. The host side has a plain write port: a write strobe, an 8-bit endpoint address and a 32-bit mask, all sampled on the host clock. When the strobe is high and the address equals the endpoint's configured address, every set mask bit requests one trigger on the output bit with the same index.

Each requested bit flips a toggle flop in the host domain. The toggle level passes through a multi-stage synchroniser into the user domain, and a change detector there turns each level change into a pulse one user-clock cycle long. Neither clock's frequency constrains the other: the user clock may run faster or slower than the host clock. The user needs no synchronisers of their own.

The block has one limit. A second trigger on the same bit must follow the first by at least three user-clock cycles. Triggers that are closer than that may merge into a single pulse or be lost.

Top module: `xtrig_endpoint`

## Requirements
- R1: While either reset is held low and after both are released, `pulse_out` is all zero until a matching write occurs; resets clear the toggle, synchroniser and detector registers.
- R2: A write whose `wr_addr` differs from `cfg_addr` produces no pulse on any bit.
- R3: With `wr_en` low, no value of `wr_addr` or `wr_mask` produces a pulse.
- R4: A matching write produces exactly one pulse on `pulse_out[i]` for every set bit `wr_mask[i]`, and none on bits whose mask bit is zero. This holds when the user clock is slower than, faster than, or at a non-integer ratio to the host clock.
- R5: Every pulse is high for exactly one user-clock cycle, whatever the clock ratio.
- R6: Bits are independent: matching writes in consecutive host cycles to different bits each deliver their own pulses.
- R7: Two triggers on the same bit whose host writes are at least three user-clock cycles apart deliver two separate pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_clk | input | 1 | Host clock |
| src_rst_n | input | 1 | Active-low reset, host domain |
| wr_en | input | 1 | Write strobe, one host cycle per write |
| wr_addr | input | 8 | Address of the write |
| wr_mask | input | 32 | Trigger request bits |
| cfg_addr | input | 8 | Address this endpoint answers to |
| dst_clk | input | 1 | User clock |
| dst_rst_n | input | 1 | Active-low reset, user domain |
| pulse_out | output | 32 | One-cycle trigger pulses in the user domain |

## Verification
The bench uses three clock ratios: a user clock three times slower than the host clock, one three times faster, and a ratio of 1.7. This separates pulses stretched to host-cycle length from pulses of true user-cycle length, and it catches edge detection that only works when the clocks are related. Single-bit, scattered multi-bit, all-ones and all-zero masks show whether each bit is routed to its own output index and fires exactly once. Mismatched addresses and a deasserted strobe show whether address decoding and the strobe gate the toggles. Back-to-back writes to different bits, and a retrigger of one bit at the minimum spacing, show whether neighbouring requests are kept apart or merged.

// File: rtl/xtrig_pkg.sv
package xtrig_pkg;

   // How the user-domain change detector presents its pulse.
   typedef enum logic {
      EDGE_COMB = 1'b0,   // pulse decoded straight from synchroniser output
      EDGE_REG  = 1'b1    // pulse registered, output driven by a flop
   } edge_mode_e;

   // Minimum legal synchroniser depth.
   localparam int unsigned MIN_SYNC_STAGES = 2;

   function automatic logic addr_hit(input logic [7:0] a, input logic [7:0] b);
      return a == b;
   endfunction

endpackage

// File: rtl/xtrig_src_toggle.sv
module xtrig_src_toggle #(
   parameter int unsigned NUM_TRIG = 32,
   parameter int unsigned ADDR_W   = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   wr_addr,
   input  logic [NUM_TRIG-1:0] wr_mask,
   input  logic [ADDR_W-1:0]   cfg_addr,
   output logic [NUM_TRIG-1:0] tog_o
);

   logic                hit;
   logic [NUM_TRIG-1:0] tog_q;

   assign hit = wr_en && (wr_addr == cfg_addr);

   // One toggle flop per trigger bit; a set mask bit flips it once.
   genvar gi;
   generate
      for (gi = 0; gi < NUM_TRIG; gi++) begin : g_tog
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               tog_q[gi] <= 1'b0;
            else if (hit && wr_mask[gi])
               tog_q[gi] <= ~tog_q[gi];
         end
      end
   endgenerate

   assign tog_o = tog_q;

   AST_NO_TOGGLE_WITHOUT_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && (wr_addr == cfg_addr)) |=> $stable(tog_q)); // R2 R3

   AST_TOGGLE_TRACKS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_addr == cfg_addr)) |=> ((tog_q ^ $past(tog_q)) == $past(wr_mask))); // R4

endmodule

// File: rtl/xtrig_sync.sv
module xtrig_sync #(
   parameter int unsigned WIDTH  = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   logic [WIDTH-1:0] stg [STAGES];

   // First stage samples the asynchronous level.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[0] <= '0;
      else        stg[0] <= d;
   end

   // Remaining stages settle metastability.
   genvar gs;
   generate
      for (gs = 1; gs < STAGES; gs++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[gs] <= '0;
            else        stg[gs] <= stg[gs-1];
         end
      end
   endgenerate

   assign q = stg[STAGES-1];

endmodule

// File: rtl/xtrig_edge_det.sv
module xtrig_edge_det
   import xtrig_pkg::*;
#(
   parameter int unsigned WIDTH = 32,
   parameter edge_mode_e  MODE  = EDGE_REG
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] lvl_i,
   output logic [WIDTH-1:0] pulse_o
);

   logic [WIDTH-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= lvl_i;
   end

   generate
      if (MODE == EDGE_REG) begin : g_reg
         logic [WIDTH-1:0] pulse_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pulse_q <= '0;
            else        pulse_q <= lvl_i ^ prev_q;
         end
         assign pulse_o = pulse_q;
      end else begin : g_comb
         assign pulse_o = lvl_i ^ prev_q;
      end
   endgenerate

   AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (|pulse_o) |=> ((pulse_o & $past(pulse_o)) == '0)); // R5

   AST_QUIET_AFTER_RESET: assert property (@(posedge clk)
      $rose(rst_n) |-> (pulse_o == '0)); // R1

endmodule

// File: rtl/xtrig_endpoint.sv
module xtrig_endpoint
   import xtrig_pkg::*;
#(
   parameter int unsigned NUM_TRIG    = 32,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter edge_mode_e  PULSE_MODE  = EDGE_REG
) (
   input  logic                src_clk,
   input  logic                src_rst_n,
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   wr_addr,
   input  logic [NUM_TRIG-1:0] wr_mask,
   input  logic [ADDR_W-1:0]   cfg_addr,
   input  logic                dst_clk,
   input  logic                dst_rst_n,
   output logic [NUM_TRIG-1:0] pulse_out
);

   localparam int unsigned TOTAL_SYNC_FLOPS = NUM_TRIG * SYNC_STAGES;

   generate
      if (NUM_TRIG < 1 || NUM_TRIG > 64) begin : g_bad_width
         $error("xtrig_endpoint: NUM_TRIG must lie in 1..64");
      end
      if (SYNC_STAGES < MIN_SYNC_STAGES || TOTAL_SYNC_FLOPS > 1024) begin : g_bad_sync
         $error("xtrig_endpoint: SYNC_STAGES out of range");
      end
      if (ADDR_W < 1) begin : g_bad_addr
         $error("xtrig_endpoint: ADDR_W must be positive");
      end
   endgenerate

   logic [NUM_TRIG-1:0] tog_src;
   logic [NUM_TRIG-1:0] tog_dst;

   xtrig_src_toggle #(
      .NUM_TRIG (NUM_TRIG),
      .ADDR_W   (ADDR_W)
   ) u_src (
      .clk      (src_clk),
      .rst_n    (src_rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_mask  (wr_mask),
      .cfg_addr (cfg_addr),
      .tog_o    (tog_src)
   );

   xtrig_sync #(
      .WIDTH  (NUM_TRIG),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (dst_clk),
      .rst_n (dst_rst_n),
      .d     (tog_src),
      .q     (tog_dst)
   );

   xtrig_edge_det #(
      .WIDTH (NUM_TRIG),
      .MODE  (PULSE_MODE)
   ) u_edge (
      .clk     (dst_clk),
      .rst_n   (dst_rst_n),
      .lvl_i   (tog_dst),
      .pulse_o (pulse_out)
   );

endmodule

// File: tb/xtrig_endpoint_bench.sv
`timescale 1ps/1ps
module xtrig_endpoint_bench;

   localparam int NT       = 32;
   localparam int SRC_HALF = 4000;            // 125 MHz host clock
   localparam longint WATCHDOG = 64'd8000 * 64'd150000;
   localparam logic [7:0] MY_ADDR = 8'h5A;

   logic          src_clk = 1'b0;
   logic          dst_clk = 1'b0;
   logic          src_rst_n = 1'b0;
   logic          dst_rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [7:0]    wr_addr = '0;
   logic [NT-1:0] wr_mask = '0;
   logic [7:0]    cfg_addr = MY_ADDR;
   logic [NT-1:0] pulse_out;
   int            dst_half = 12000;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   int obs_cnt [NT];
   int exp_cnt [NT];
   int long_cnt = 0;
   logic [NT-1:0] last_smp = '0;

   xtrig_endpoint u_xtrig_endpoint (
      .src_clk   (src_clk),
      .src_rst_n (src_rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_mask   (wr_mask),
      .cfg_addr  (cfg_addr),
      .dst_clk   (dst_clk),
      .dst_rst_n (dst_rst_n),
      .pulse_out (pulse_out)
   );

   always #(SRC_HALF) src_clk = ~src_clk;
   initial forever #(dst_half) dst_clk = ~dst_clk;

   // Monitor: sample between user-clock edges, count pulses and overlong pulses.
   always @(negedge dst_clk) begin
      for (int i = 0; i < NT; i++) begin
         if (pulse_out[i] === 1'b1) obs_cnt[i] = obs_cnt[i] + 1;
         if (pulse_out[i] === 1'b1 && last_smp[i] === 1'b1) long_cnt = long_cnt + 1;
      end
      last_smp = pulse_out;
   end

   task automatic clear_counts();
      for (int i = 0; i < NT; i++) begin
         obs_cnt[i] = 0;
         exp_cnt[i] = 0;
      end
      long_cnt = 0;
   endtask

   task automatic expect_mask(input logic [NT-1:0] m);
      for (int i = 0; i < NT; i++) if (m[i]) exp_cnt[i] = exp_cnt[i] + 1;
   endtask

   task automatic host_write(input logic [7:0] a, input logic [NT-1:0] m, input logic en);
      @(negedge src_clk);
      wr_en = en; wr_addr = a; wr_mask = m;
      @(negedge src_clk);
      wr_en = 1'b0; wr_mask = '0;
   endtask

   task automatic drain();
      repeat (10) @(posedge dst_clk);
      repeat (2) @(negedge src_clk);
   endtask

   task automatic check_counts(input string req, input string what);
      int bad = -1;
      checks++;
      for (int i = 0; i < NT; i++) if (bad < 0 && obs_cnt[i] != exp_cnt[i]) bad = i;
      if (bad >= 0) begin
         errors++;
         $display("FAIL %s %s: bit %0d pulses actual %0d expected %0d",
                  req, what, bad, obs_cnt[bad], exp_cnt[bad]);
      end
   endtask

   task automatic check_width(input string what);
      checks++;
      if (long_cnt != 0) begin
         errors++;
         $display("FAIL R5 %s: overlong pulse samples actual %0d expected 0", what, long_cnt);
      end
   endtask

   task automatic do_reset();
      src_rst_n = 1'b0; dst_rst_n = 1'b0;
      repeat (3) @(negedge src_clk);
      repeat (3) @(negedge dst_clk);
      src_rst_n = 1'b1; dst_rst_n = 1'b1;
      repeat (2) @(negedge src_clk);
      clear_counts();
   endtask

   // R1: outputs quiet during and after reset.
   task automatic t_reset_state();
      src_rst_n = 1'b0; dst_rst_n = 1'b0;
      repeat (3) @(negedge dst_clk);
      checks++;
      if (pulse_out !== '0) begin
         errors++;
         $display("FAIL R1 in reset: pulse_out actual %h expected 0", pulse_out);
      end
      src_rst_n = 1'b1; dst_rst_n = 1'b1;
      clear_counts();
      drain();
      check_counts("R1", "idle after reset");
   endtask

   // R2: mismatched addresses never fire.
   task automatic t_addr_miss();
      clear_counts();
      host_write(MY_ADDR ^ 8'h01, '1, 1'b1);
      host_write(MY_ADDR ^ 8'h80, 32'h0000_FFFF, 1'b1);
      host_write(8'h00, 32'h8000_0001, 1'b1);
      drain();
      check_counts("R2", "address mismatch");
   endtask

   // R3: strobe low never fires, even with matching address.
   task automatic t_wren_low();
      clear_counts();
      host_write(MY_ADDR, '1, 1'b0);
      host_write(MY_ADDR, 32'hA5A5_5A5A, 1'b0);
      drain();
      check_counts("R3", "strobe low");
   endtask

   // R4: mask bits map to output bits, one pulse each.
   task automatic t_patterns(input string tag);
      logic [NT-1:0] pats [5];
      pats[0] = 32'h0000_0001;
      pats[1] = 32'h8000_0000;
      pats[2] = 32'h1248_0C30;
      pats[3] = 32'h0000_0000;
      pats[4] = 32'hFFFF_FFFF;
      clear_counts();
      for (int p = 0; p < 5; p++) begin
         host_write(MY_ADDR, pats[p], 1'b1);
         expect_mask(pats[p]);
         drain();
      end
      check_counts("R4", tag);
      check_width(tag);
   endtask

   // R6: consecutive host cycles, different bits.
   task automatic t_back_to_back(input string tag);
      clear_counts();
      @(negedge src_clk);
      wr_en = 1'b1; wr_addr = MY_ADDR; wr_mask = 32'h0000_0010;
      @(negedge src_clk);
      wr_mask = 32'h0001_0000;
      @(negedge src_clk);
      wr_mask = 32'h4000_0002;
      @(negedge src_clk);
      wr_en = 1'b0; wr_mask = '0;
      expect_mask(32'h4001_0012);
      drain();
      check_counts("R6", tag);
   endtask

   // R7: same bit retriggered after three user cycles.
   task automatic t_retrigger(input string tag);
      clear_counts();
      host_write(MY_ADDR, 32'h0000_0020, 1'b1);
      repeat (3) @(posedge dst_clk);
      host_write(MY_ADDR, 32'h0000_0020, 1'b1);
      exp_cnt[5] = 2;
      drain();
      check_counts("R7", tag);
      check_width(tag);
   endtask

   task automatic run_ratio(input int half, input string tag);
      dst_half = half;
      repeat (4) @(posedge dst_clk);
      do_reset();
      t_patterns(tag);
      t_back_to_back(tag);
      t_retrigger(tag);
   endtask

   initial begin
      clear_counts();
      repeat (4) @(negedge src_clk);
      t_reset_state();
      t_addr_miss();
      t_wren_low();
      run_ratio(12000, "user 3x slower");
      run_ratio(1333,  "user 3x faster");
      run_ratio(6800,  "ratio 1.7");
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(WATCHDOG);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run actual unfinished expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule